// File: doc/BRIEF.md
# Identifier Digit Sequence Player with Seven-Segment Output

This block plays back a fixed, repeating run of decimal digits built at elaboration time from an eight-digit identifier parameter. The run starts with the identifier digits in order, leftmost digit first. Two zero digits follow. Then comes a second pass over the identifier in which each digit is raised by one, modulo ten. After the final digit the run starts again at the beginning. The current digit is driven out as a 4-bit value. It is also driven as an active-low pattern for a single seven-segment display.

The sequencing state is a three-phase state machine with a small index register. The phases are `PH_IDENT` for the identifier pass, `PH_PAD` for the two zeros and `PH_BUMP` for the raised pass. The transitions are:
- `PH_IDENT` at the last index goes to `PH_PAD` index 0.
- `PH_PAD` at index 1 goes to `PH_BUMP` index 0.
- `PH_BUMP` at the last index goes back to `PH_IDENT` index 0.
- Any other step stays in the same phase and adds one to the index.
- A step is taken only on clock edges where the step enable is high.

With eight digits the state is 5 flip-flops. The digit and the glyph are decoded combinationally from that state, so there is no added pipeline stage. An identifier digit above 9 stops elaboration.

Top module: `idseq_display`

## Requirements
- R1: When a clock edge samples `rst` high, the block goes to position 0. From the next cycle on, `digit` shows the leftmost identifier digit, which is bits [4N-1:4N-4] of `ID_VALUE`.
- R2: Positions 0 to N-1 show the identifier digits in order, leftmost (most significant nibble) first.
- R3: Positions N and N+1 both show digit 0.
- R4: Positions N+2 to 2N+1 show the identifier digits in order, each one plus one modulo ten, so 9 is shown as 0.
- R5: A step taken from the last position (2N+1, which is 17 for eight digits) returns to position 0.
- R6: On an edge where `step_en` is low and `rst` is low, the position is held, so `digit` and `seg_n` do not change.
- R7: `seg_n` is the active-low hexadecimal glyph of `digit`. Bit 0 is segment a, on through bit 6 for segment g, and a 0 lights a segment. Digit 1 gives 7'b1111001 and digit 8 gives 7'b0000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Advance to the next position on this edge |
| digit | output | 4 | Digit at the current position |
| seg_n | output | 7 | Active-low segment drive, bit 0 = a through bit 6 = g |

## Verification
Both outputs are decoded directly from the state register. A reset or a step sampled on a rising edge is therefore visible within that same clock period, just after the edge. The scoreboard sets up each stimulus half a period before the edge and works out the expected digit and glyph from its own model of the sequence. The monitor compares the outputs 1 ns after the following rising edge, which keeps every comparison exactly one edge behind its stimulus and clear of that edge.

// File: rtl/idseq_pkg.sv
package idseq_pkg;

    typedef enum logic [1:0] {
        PH_IDENT = 2'd0,
        PH_PAD   = 2'd1,
        PH_BUMP  = 2'd2
    } phase_t;

    localparam int PAD_COUNT = 2;

endpackage

// File: rtl/idseq_fsm.sv
module idseq_fsm #(
    parameter int N_DIGITS = 8,
    parameter int IDX_W    = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  step_en,
    output idseq_pkg::phase_t     phase,
    output logic [IDX_W-1:0]      idx
);
    import idseq_pkg::*;

    localparam logic [IDX_W-1:0] LAST_ID  = IDX_W'(N_DIGITS - 1);
    localparam logic [IDX_W-1:0] LAST_PAD = IDX_W'(PAD_COUNT - 1);

    phase_t           phase_q, phase_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDENT;
            idx_q   <= '0;
        end else if (step_en) begin
            phase_q <= phase_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        phase_d = phase_q;
        idx_d   = idx_q + 1'b1;
        unique case (phase_q)
            PH_IDENT: begin
                if (idx_q == LAST_ID) begin
                    phase_d = PH_PAD;
                    idx_d   = '0;
                end
            end
            PH_PAD: begin
                if (idx_q == LAST_PAD) begin
                    phase_d = PH_BUMP;
                    idx_d   = '0;
                end
            end
            PH_BUMP: begin
                if (idx_q == LAST_ID) begin
                    phase_d = PH_IDENT;
                    idx_d   = '0;
                end
            end
            default: begin
                phase_d = PH_IDENT;
                idx_d   = '0;
            end
        endcase
    end

    assign phase = phase_q;
    assign idx   = idx_q;

endmodule

// File: rtl/idseq_digit_lut.sv
module idseq_digit_lut #(
    parameter int                    N_DIGITS = 8,
    parameter int                    IDX_W    = 3,
    parameter logic [4*N_DIGITS-1:0] ID       = 32'h90451786
) (
    input  idseq_pkg::phase_t  phase,
    input  logic [IDX_W-1:0]   idx,
    output logic [3:0]         digit
);
    import idseq_pkg::*;

    logic [3:0] id_tab   [N_DIGITS];
    logic [3:0] bump_tab [N_DIGITS];

    for (genvar k = 0; k < N_DIGITS; k++) begin : g_tab
        localparam logic [3:0] SRC = ID[4*(N_DIGITS-1-k) +: 4];
        if (SRC > 4'd9) begin : g_bad_digit
            $error("identifier digit %0d is not a decimal digit", k);
        end
        assign id_tab[k]   = SRC;
        assign bump_tab[k] = (SRC == 4'd9) ? 4'd0 : SRC + 4'd1;
    end

    always_comb begin
        digit = 4'd0;
        unique case (phase)
            PH_IDENT: digit = (32'(idx) < N_DIGITS) ? id_tab[idx]   : 4'd0;
            PH_PAD:   digit = 4'd0;
            PH_BUMP:  digit = (32'(idx) < N_DIGITS) ? bump_tab[idx] : 4'd0;
            default:  digit = 4'd0;
        endcase
    end

endmodule

// File: rtl/hex7_enc.sv
module hex7_enc (
    input  logic [3:0] val,
    output logic [6:0] seg_n
);
    logic [6:0] lit;

    always_comb begin
        unique case (val)
            4'h0: lit = 7'h3F;
            4'h1: lit = 7'h06;
            4'h2: lit = 7'h5B;
            4'h3: lit = 7'h4F;
            4'h4: lit = 7'h66;
            4'h5: lit = 7'h6D;
            4'h6: lit = 7'h7D;
            4'h7: lit = 7'h07;
            4'h8: lit = 7'h7F;
            4'h9: lit = 7'h6F;
            4'hA: lit = 7'h77;
            4'hB: lit = 7'h7C;
            4'hC: lit = 7'h39;
            4'hD: lit = 7'h5E;
            4'hE: lit = 7'h79;
            4'hF: lit = 7'h71;
            default: lit = 7'h00;
        endcase
    end

    assign seg_n = ~lit;

endmodule

// File: rtl/idseq_display.sv
module idseq_display #(
    parameter int                    ID_DIGITS = 8,
    parameter logic [4*ID_DIGITS-1:0] ID_VALUE = 32'h90451786
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       step_en,
    output logic [3:0] digit,
    output logic [6:0] seg_n
);
    import idseq_pkg::*;

    localparam int IDX_W = ($clog2(ID_DIGITS) < 1) ? 1 : $clog2(ID_DIGITS);

    phase_t           cur_phase;
    logic [IDX_W-1:0] cur_idx;

    idseq_fsm #(
        .N_DIGITS (ID_DIGITS),
        .IDX_W    (IDX_W)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .step_en (step_en),
        .phase   (cur_phase),
        .idx     (cur_idx)
    );

    idseq_digit_lut #(
        .N_DIGITS (ID_DIGITS),
        .IDX_W    (IDX_W),
        .ID       (ID_VALUE)
    ) u_lut (
        .phase (cur_phase),
        .idx   (cur_idx),
        .digit (digit)
    );

    hex7_enc u_enc (
        .val   (digit),
        .seg_n (seg_n)
    );

endmodule

// File: rtl/idseq_checker.sv
module idseq_checker #(
    parameter int              N     = 8,
    parameter int              IDX_W = 3,
    parameter logic [4*N-1:0]  ID    = 32'h90451786
) (
    input logic              clk,
    input logic              rst,
    input logic              step_en,
    input logic [3:0]        digit,
    input logic [6:0]        seg_n,
    input idseq_pkg::phase_t phase,
    input logic [IDX_W-1:0]  idx
);
    import idseq_pkg::*;

    localparam logic [3:0] FIRST = ID[4*N-1 -: 4];

    // R1: a sampled reset leaves the first identifier digit on the output
    a_r1_reset_first: assert property (@(posedge clk)
        rst |=> (digit == FIRST));

    // R3: the padding phase drives zero
    a_r3_pad_zero: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_PAD) |-> (digit == 4'd0));

    // R4: the raised pass stays decimal
    a_r4_bump_decimal: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_BUMP) |-> (digit <= 4'd9));

    // R6: no step, no change
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> ($stable(digit) && $stable(seg_n)));

    // R7: the glyph for one lights exactly segments b and c
    a_r7_glyph_one: assert property (@(posedge clk) disable iff (rst)
        (digit == 4'd1) |-> (seg_n == 7'b1111001));

    // R7: every decimal glyph lights at least two segments
    a_r7_glyph_lit: assert property (@(posedge clk) disable iff (rst)
        (digit <= 4'd9) |-> ($countones(~seg_n) >= 2));

endmodule

bind idseq_display idseq_checker #(
    .N     (ID_DIGITS),
    .IDX_W (IDX_W),
    .ID    (ID_VALUE)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .step_en (step_en),
    .digit   (digit),
    .seg_n   (seg_n),
    .phase   (cur_phase),
    .idx     (cur_idx)
);

// File: tb/sim_idseq_display.sv
module sim_idseq_display;

    localparam int           N      = 8;
    localparam logic [31:0]  IDV    = 32'h90451786;
    localparam int           SEQLEN = 2 * N + 2;

    typedef struct {
        int    d;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       step_en = 1'b0;
    logic [3:0] digit;
    logic [6:0] seg_n;

    int   checks = 0;
    int   fails  = 0;
    int   pos    = 0;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    idseq_display #(.ID_DIGITS(N), .ID_VALUE(IDV)) u0 (
        .clk     (clk),
        .rst     (rst),
        .step_en (step_en),
        .digit   (digit),
        .seg_n   (seg_n)
    );

    function automatic int id_at(int k);
        return (IDV >> (4 * (N - 1 - k))) & 15;
    endfunction

    function automatic int exp_digit(int p);
        if (p < N)      return id_at(p);
        if (p < N + 2)  return 0;
        return (id_at(p - N - 2) + 1) % 10;
    endfunction

    function automatic logic [6:0] exp_glyph(int d);
        case (d)
            0: return 7'b1000000;
            1: return 7'b1111001;
            2: return 7'b0100100;
            3: return 7'b0110000;
            4: return 7'b0011001;
            5: return 7'b0010010;
            6: return 7'b0000010;
            7: return 7'b1111000;
            8: return 7'b0000000;
            9: return 7'b0010000;
            default: return 7'b1111111;
        endcase
    endfunction

    function automatic string pos_tag(int p);
        if (p < N)     return "R2";
        if (p < N + 2) return "R3";
        return "R4";
    endfunction

    // driver: one cycle of stimulus, one expected item
    task automatic drive(input logic r, input logic en);
        exp_t e;
        int   prev;
        @(negedge clk);
        rst     = r;
        step_en = en;
        prev    = pos;
        if (r)       pos = 0;
        else if (en) pos = (pos + 1) % SEQLEN;
        e.d = exp_digit(pos);
        if (r)                                e.tag = "R1";
        else if (!en)                         e.tag = "R6";
        else if (prev == SEQLEN - 1)          e.tag = "R5";
        else                                  e.tag = pos_tag(pos);
        sb_q.push_back(e);
    endtask

    // monitor: compare 1 ns after each rising edge
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (32'(digit) != e.d) begin
                fails++;
                $display("FAIL %s digit: actual %0d expected %0d", e.tag, digit, e.d);
            end
            checks++;
            if (seg_n != exp_glyph(e.d)) begin
                fails++;
                $display("FAIL R7 seg_n (%s): actual %b expected %b",
                         e.tag, seg_n, exp_glyph(e.d));
            end
        end
    end

    initial begin
        // R1: reset state
        drive(1'b1, 1'b0);
        drive(1'b1, 1'b1);
        // R2 R3 R4 R5: two full laps plus a few steps
        for (int i = 0; i < 2 * SEQLEN + 4; i++) drive(1'b0, 1'b1);
        // R6: hold with enable low
        for (int i = 0; i < 4; i++) drive(1'b0, 1'b0);
        // alternating enable pattern across the pad and wrap points
        for (int i = 0; i < 3 * SEQLEN; i++) drive(1'b0, (i % 3) != 1);
        // R1: reset from mid sequence
        drive(1'b1, 1'b1);
        drive(1'b0, 1'b0);
        for (int i = 0; i < SEQLEN + 1; i++) drive(1'b0, 1'b1);
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(4ns * 20000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule